// File: doc/BRIEF.md
# Single and Dual-Lane Serial Flash Read Engine

This block runs the array-read part of a 512 KB serial flash slave. A command front-end samples the opcode byte and hands it over with a one-cycle valid strobe. The engine accepts four read opcodes and ignores all others. It then collects a 24-bit address on one or two lanes and counts the dummy clocks the opcode needs. After that it streams array bytes from a synchronous memory port out on one lane or on two lanes, and keeps doing so until chip select is released.

The serial clock is not used as a clock. It arrives as single-cycle rise and fall strobes on the system clock domain. Inputs are taken on rise strobes and outputs change on fall strobes. The engine prefetches one byte ahead of the shifter. A hold input freezes the serial sequence and releases the output lanes. Raising chip select abandons any phase. Edge strobes must be at least four system clocks apart.

Top module: `flash_read_engine`

## Requirements
- R1: After reset, `sio_oe` is 2'b00 and `mem_rd_en` is low.
- R2: Opcode 03h takes 24 address bits on lane 0 (`sio_in[0]`), MSB first, one per rise, and has no dummy clocks. Data comes out MSB first on lane 1 (`sio_out[1]`). The first bit appears at the fall that follows the last address rise. `sio_oe` is 2'b10 while data is driven.
- R3: Opcode 0Bh behaves like R2, with 8 dummy rises between the address and the data.
- R4: Opcode 3Bh takes the address on lane 0 and then 8 dummy rises. It then outputs each byte in 4 falls on both lanes (`sio_oe` = 2'b11). Lane 1 carries bits 7,5,3,1 and lane 0 carries bits 6,4,2,0. Neither lane is driven during the address or dummy phases.
- R5: Opcode BBh takes the address in 12 rises, two bits per rise, with lane 1 holding the more significant bit. It then takes 4 dummy rises and outputs data as in R4.
- R6: Only the low 19 address bits select the array byte. The upper 5 bits received are ignored.
- R7: Bytes keep coming from consecutive addresses while chip select stays low. After address 7FFFFh the next byte comes from address 0.
- R8: While `hold_n` is low, both lanes are released and rise and fall strobes are ignored. When `hold_n` returns high, output resumes at the same bit with no data lost.
- R9: Raising `cs_n` returns the engine to idle from any phase. The lanes are released and the next command starts cleanly.
- R10: A command strobe whose opcode is not one of 03h, 0Bh, 3Bh or BBh is ignored. No lane is driven and no memory read is made.
- R11: `mem_rd_en` is raised only in the data phase. It is raised once for the first byte, one cycle after the last address or dummy rise, and then once each time a byte is loaded into the shifter. A read of N bytes therefore makes N+1 memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Hold, active low |
| sck_rise | input | 1 | Single-cycle strobe marking a serial clock rising edge |
| sck_fall | input | 1 | Single-cycle strobe marking a serial clock falling edge |
| cmd_valid | input | 1 | Opcode strobe from the command front-end |
| cmd_op | input | 8 | Opcode byte |
| sio_in | input | 2 | Serial lane inputs (bit 0 = lane 0) |
| sio_out | output | 2 | Serial lane outputs |
| sio_oe | output | 2 | Per-lane output enables |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 19 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |

## Verification
A rise strobe is registered at one clock edge and moves the phase on at that same edge. The first memory read is requested one cycle later, and its data is captured two cycles after the rise. Each fall strobe changes `sio_out` and `sio_oe` at the edge where it is registered. A rise of `cs_n` clears the lane enables within two cycles.

The bench spaces every strobe five system clocks apart, and it samples on the falling system-clock edge three clocks after each fall strobe. Each sample therefore lands well after the output has settled and well before the next edge can change it. It counts memory reads over each whole transaction and compares the count once the last fall has settled.

// File: rtl/frd_pkg.sv
`timescale 1ns/1ps
package frd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  typedef struct packed {
    logic valid;
    logic dual_addr;
    logic dual_data;
    logic has_dummy;
  } mode_t;

  localparam logic [7:0] OP_PLAIN = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_DOUT  = 8'h3B;
  localparam logic [7:0] OP_DIO   = 8'hBB;

  function automatic mode_t decode_op(input logic [7:0] op);
    mode_t m;
    m = '0;
    case (op)
      OP_PLAIN: m = '{valid: 1'b1, dual_addr: 1'b0, dual_data: 1'b0, has_dummy: 1'b0};
      OP_FAST:  m = '{valid: 1'b1, dual_addr: 1'b0, dual_data: 1'b0, has_dummy: 1'b1};
      OP_DOUT:  m = '{valid: 1'b1, dual_addr: 1'b0, dual_data: 1'b1, has_dummy: 1'b1};
      OP_DIO:   m = '{valid: 1'b1, dual_addr: 1'b1, dual_data: 1'b1, has_dummy: 1'b1};
      default:  m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/frd_phase_ctrl.sv
`timescale 1ns/1ps
module frd_phase_ctrl
  import frd_pkg::*;
#(
  parameter int CMD_AW = 24,
  parameter int BYTE_W = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_n,
  input  logic   hold_n,
  input  logic   sck_rise,
  input  logic   sck_fall,
  input  logic   cmd_valid,
  input  logic [7:0] cmd_op,
  output phase_e phase,
  output logic   dual_addr,
  output logic   dual_data,
  output logic   addr_shift,
  output logic   fall_ok,
  output logic   data_go
);

  localparam int CNT_MAX = (CMD_AW > BYTE_W) ? CMD_AW : BYTE_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] ADDR_SGL = CNT_W'(CMD_AW - 1);
  localparam logic [CNT_W-1:0] ADDR_DUO = CNT_W'(CMD_AW / 2 - 1);
  localparam logic [CNT_W-1:0] DUM_SGL  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] DUM_DUO  = CNT_W'(BYTE_W / 2 - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  mode_t            mode_q, mode_d;
  mode_t            dec;
  logic             go_q, go_d;
  logic             rise_ok;

  assign dec     = decode_op(cmd_op);
  assign rise_ok = sck_rise & hold_n & ~cs_n;
  assign fall_ok = sck_fall & hold_n & ~cs_n;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    go_d    = 1'b0;
    if (cs_n) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (cmd_valid && dec.valid) begin
            mode_d  = dec;
            phase_d = PH_ADDR;
            cnt_d   = dec.dual_addr ? ADDR_DUO : ADDR_SGL;
          end
        end
        PH_ADDR: begin
          if (rise_ok) begin
            if (cnt_q == '0) begin
              if (mode_q.has_dummy) begin
                phase_d = PH_DUMMY;
                cnt_d   = mode_q.dual_addr ? DUM_DUO : DUM_SGL;
              end else begin
                phase_d = PH_DATA;
                go_d    = 1'b1;
              end
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        PH_DUMMY: begin
          if (rise_ok) begin
            if (cnt_q == '0) begin
              phase_d = PH_DATA;
              go_d    = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      mode_q  <= '0;
      go_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      go_q    <= go_d;
    end
  end

  assign phase      = phase_q;
  assign dual_addr  = mode_q.dual_addr;
  assign dual_data  = mode_q.dual_data;
  assign addr_shift = rise_ok & (phase_q == PH_ADDR);
  assign data_go    = go_q & (phase_q == PH_DATA);

  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> phase_q == PH_IDLE);

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n && phase_q != PH_IDLE) |=> ($stable(phase_q) && $stable(cnt_q)));

endmodule

// File: rtl/frd_addr_unit.sv
`timescale 1ns/1ps
module frd_addr_unit #(
  parameter int ARRAY_AW = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                dual,
  input  logic [1:0]          lanes,
  input  logic                inc,
  output logic [ARRAY_AW-1:0] addr
);

  logic [ARRAY_AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (shift_en) begin
      addr_d = dual ? {addr_q[ARRAY_AW-3:0], lanes}
                    : {addr_q[ARRAY_AW-2:0], lanes[0]};
    end else if (inc) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/frd_serializer.sv
`timescale 1ns/1ps
module frd_serializer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_data,
  input  logic              fall_ok,
  input  logic              hold_n,
  input  logic              dual,
  input  logic              go,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_rd_en,
  output logic [1:0]        sio_out,
  output logic [1:0]        sio_oe
);

  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] BEATS_SGL = BC_W'(BYTE_W - 1);
  localparam logic [BC_W-1:0] BEATS_DUO = BC_W'(BYTE_W / 2 - 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] nxt_q, nxt_d;
  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  logic              drv_q, drv_d;
  logic              pend_q;
  logic              issue;

  assign issue = in_data & (go | (fall_ok & (bcnt_q == '0)));

  always_comb begin
    sh_d   = sh_q;
    nxt_d  = nxt_q;
    bcnt_d = bcnt_q;
    drv_d  = drv_q;
    if (pend_q) nxt_d = mem_rdata;
    if (!in_data) begin
      bcnt_d = '0;
      drv_d  = 1'b0;
    end else if (fall_ok) begin
      drv_d = 1'b1;
      if (bcnt_q == '0) begin
        sh_d   = nxt_q;
        bcnt_d = dual ? BEATS_DUO : BEATS_SGL;
      end else begin
        sh_d   = dual ? (sh_q << 2) : (sh_q << 1);
        bcnt_d = bcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      nxt_q  <= '0;
      bcnt_q <= '0;
      drv_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      nxt_q  <= nxt_d;
      bcnt_q <= bcnt_d;
      drv_q  <= drv_d;
      pend_q <= issue;
    end
  end

  assign mem_rd_en = issue;
  assign sio_out   = dual ? sh_q[BYTE_W-1 -: 2] : {sh_q[BYTE_W-1], 1'b0};
  assign sio_oe    = (drv_q & hold_n & in_data) ? (dual ? 2'b11 : 2'b10) : 2'b00;

  // R8
  hold_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> $stable(sh_q));

endmodule

// File: rtl/flash_read_engine.sv
`timescale 1ns/1ps
module flash_read_engine
  import frd_pkg::*;
#(
  parameter int ARRAY_AW = 19,
  parameter int CMD_AW   = 24,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                hold_n,
  input  logic                sck_rise,
  input  logic                sck_fall,
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_op,
  input  logic [1:0]          sio_in,
  output logic [1:0]          sio_out,
  output logic [1:0]          sio_oe,
  output logic                mem_rd_en,
  output logic [ARRAY_AW-1:0] mem_addr,
  input  logic [BYTE_W-1:0]   mem_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  phase_e phase;
  logic   dual_addr, dual_data, addr_shift, fall_ok, data_go;

  frd_phase_ctrl #(.CMD_AW(CMD_AW), .BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_i), .cs_n(cs_n), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .phase(phase), .dual_addr(dual_addr), .dual_data(dual_data),
    .addr_shift(addr_shift), .fall_ok(fall_ok), .data_go(data_go)
  );

  frd_addr_unit #(.ARRAY_AW(ARRAY_AW)) addr_i (
    .clk(clk), .rst_n(rst_i), .shift_en(addr_shift), .dual(dual_addr),
    .lanes(sio_in), .inc(mem_rd_en), .addr(mem_addr)
  );

  frd_serializer #(.BYTE_W(BYTE_W)) ser_i (
    .clk(clk), .rst_n(rst_i), .in_data(phase == PH_DATA), .fall_ok(fall_ok),
    .hold_n(hold_n), .dual(dual_data), .go(data_go), .mem_rdata(mem_rdata),
    .mem_rd_en(mem_rd_en), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  // R11
  rd_in_data_chk: assert property (@(posedge clk) disable iff (!rst_i)
    mem_rd_en |-> phase == PH_DATA);

  // R2
  sgl_lane0_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (phase == PH_DATA && !dual_data) |-> !sio_oe[0]);

  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (phase == PH_IDLE && cmd_valid && !decode_op(cmd_op).valid) |=> phase == PH_IDLE);

endmodule

// File: tb/flash_read_engine_tb_top.sv
`timescale 1ns/1ps
module flash_read_engine_tb_top;

  logic        clk;
  logic        rst_n, cs_n, hold_n, sck_rise, sck_fall, cmd_valid;
  logic [7:0]  cmd_op;
  logic [1:0]  sio_in, sio_out, sio_oe;
  logic        mem_rd_en;
  logic [18:0] mem_addr;
  logic [7:0]  mem_rdata;
  int          n_chk, n_fail, rd_cnt;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  flash_read_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mbyte(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
  endfunction

  initial rd_cnt = 0;
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mbyte(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  nbytes;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{op: 8'h03, addr: 24'h000010, nbytes: 8'd3, tag: 4'd2},
    '{op: 8'h0B, addr: 24'h0123AB, nbytes: 8'd2, tag: 4'd3},
    '{op: 8'h3B, addr: 24'h045A70, nbytes: 8'd3, tag: 4'd4},
    '{op: 8'hBB, addr: 24'h0A5C3E, nbytes: 8'd3, tag: 4'd5},
    '{op: 8'h03, addr: 24'hF4321C, nbytes: 8'd2, tag: 4'd6},
    '{op: 8'h3B, addr: 24'h07FFFE, nbytes: 8'd4, tag: 4'd7},
    '{op: 8'hBB, addr: 24'hE7FFFF, nbytes: 8'd2, tag: 4'd7}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_rise();
    @(negedge clk) sck_rise = 1'b1;
    @(negedge clk) sck_rise = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_fall();
    @(negedge clk) sck_fall = 1'b1;
    @(negedge clk) sck_fall = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] op);
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk) cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                         input int hold_beat, input string tag);
    bit dual_a, dual_d;
    int n_addr, n_dum, n_in, bpb, beats, bad_oe, rd0;
    logic [7:0]  acc;
    logic [18:0] ea;
    logic [1:0]  oe_exp, held;
    dual_a = (op == 8'hBB);
    dual_d = (op == 8'h3B) || (op == 8'hBB);
    n_addr = dual_a ? 12 : 24;
    n_dum  = (op == 8'h03) ? 0 : (dual_a ? 4 : 8);
    n_in   = n_addr + n_dum;
    bpb    = dual_d ? 4 : 8;
    beats  = nbytes * bpb;
    oe_exp = dual_d ? 2'b11 : 2'b10;
    bad_oe = 0;
    acc    = '0;
    rd0    = rd_cnt;
    send_cmd(op);
    for (int c = 0; c < n_in + beats - 1; c++) begin
      if (c < n_addr) sio_in = dual_a ? {a[23-2*c], a[22-2*c]} : {1'b0, a[23-c]};
      else            sio_in = 2'b00;
      if (hold_beat >= 0 && c == n_in + hold_beat) begin
        held   = sio_out;
        hold_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 lanes released in hold", {30'd0, sio_oe}, 32'd0);
        pulse_rise();
        pulse_fall();
        hold_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 drive resumes after hold", {30'd0, sio_oe}, {30'd0, oe_exp});
        chk("R8 output bit kept over hold", {30'd0, sio_out}, {30'd0, held});
      end
      pulse_rise();
      pulse_fall();
      if (c < n_in - 1) begin
        if (sio_oe !== 2'b00) bad_oe++;
      end else begin
        if (sio_oe !== oe_exp) bad_oe++;
        acc = dual_d ? {acc[5:0], sio_out} : {acc[6:0], sio_out[1]};
        if (((c - (n_in - 1)) % bpb) == bpb - 1) begin
          ea = a[18:0] + 19'((c - (n_in - 1)) / bpb);
          chk({tag, " data byte"}, {24'd0, acc}, {24'd0, mbyte(ea)});
        end
      end
    end
    chk({tag, " lane enables per phase"}, bad_oe, 0);
    chk("R11 memory reads per transaction", rd_cnt - rd0, nbytes + 1);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 lanes released on deselect", {30'd0, sio_oe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int rd0, bad;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cs_n = 1'b1; hold_n = 1'b1; sck_rise = 1'b0; sck_fall = 1'b0;
    cmd_valid = 1'b0; cmd_op = 8'h00; sio_in = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 lane enables after reset", {30'd0, sio_oe}, 32'd0);
    chk("R1 no memory read after reset", {31'd0, mem_rd_en}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++)
      do_read(VEC[i].op, VEC[i].addr, int'(VEC[i].nbytes), -1, tag_name(VEC[i].tag));

    // R8 hold in single and dual data phases
    do_read(8'h0B, 24'h033333, 3, 5, "R8");
    do_read(8'hBB, 24'h012345, 3, 6, "R8");

    // R9 abort during address, then a clean read
    send_cmd(8'h03);
    sio_in = 2'b11;
    for (int c = 0; c < 10; c++) begin
      pulse_rise();
      pulse_fall();
    end
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle after address abort", {30'd0, sio_oe}, 32'd0);
    do_read(8'h03, 24'h00ABCD, 2, -1, "R9");

    // R10 unknown opcode ignored
    rd0 = rd_cnt;
    bad = 0;
    send_cmd(8'h9F);
    for (int c = 0; c < 40; c++) begin
      sio_in = c[1:0];
      pulse_rise();
      pulse_fall();
      if (sio_oe !== 2'b00) bad++;
    end
    chk("R10 no lane driven for unknown opcode", bad, 0);
    chk("R10 no memory read for unknown opcode", rd_cnt - rd0, 0);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule